// File: doc/BRIEF.md
# Ranked Peripheral Pin Allocator

This block places the output and input lines of a fixed set of on-chip peripherals onto 24 general-purpose pins, numbered 0 to 23 as three 8-bit ports (pin 8k+b is bit b of port k). Software does not choose a pin for each signal. It only enables peripherals and marks pins to keep out of the allocation. The allocator walks the signals from highest to lowest rank and gives each enabled one the lowest-numbered pin that is still free. The two UART lines are the exception: they always sit on pins 4 and 5.

Pins reserved for analog inputs, references, oscillator pads or plain GPIO are removed from the allocation through the per-pin skip masks. Pins that end up with no signal are driven from the GPIO port latch. The allocation is computed combinationally from the configuration pins and held in a register that is updated on every rising clock edge, so a configuration change takes effect one edge later. A parameter sets how many pins of port 2 exist. A signal that finds no free pin stays unplaced, and an overflow flag reports it.

Top module: `pin_xbar`

## Requirements
- R1: Signal codes, in descending rank: TX=0, RX=1, SCK=2, MISO=3, MOSI=4, NSS=5, SDA=6, SCL=7, CP=8, CPA=9, SYSCLK=10, CEX0=11, CEX1=12, CEX2=13, ECI=14, T0=15, T1=16. Each requested signal from code 2 upward, taken in code order, is placed on the lowest-numbered pin that is not skipped, not beyond the port-2 limit and not already given to an earlier signal. No signal occupies more than one pin.
- R2: A pin whose skip bit is set never receives a signal of code 2 or above. The skip bit for pin p is bit p%8 of `skip_p0`, `skip_p1` or `skip_p2`, chosen by p/8.
- R3: When `uart_en` is 1, TX is placed on pin 4 and RX on pin 5 regardless of the skip bits, and both pins are unavailable to every other signal.
- R4: Request mapping: `uart_en` requests TX and RX; `spi_en` requests SCK, MISO and MOSI; NSS is requested only when both `spi_en` and `spi_4w` are 1; `i2c_en` requests SDA and SCL; `cmp_en` requests CP and `cmp_async_en` requests CPA; `sysclk_en` requests SYSCLK; CEXk is requested when `pca_chans` > k; `eci_en`, `t0_en` and `t1_en` each request their own signal.
- R5: Pins 16+P2_PINS to 23 never receive a signal. `overflow` is 1 exactly when at least one requested signal found no free pin, and that signal stays unplaced.
- R6: A pin with no signal reads `pin_sel` code 31 and drives `pin_out` = `gpio_latch` bit with `pin_oe` = 1.
- R7: A pin carrying signal s drives `pin_out` = `sig_out[s]` and `pin_oe` = `sig_oe[s]`.
- R8: `sig_in[s]` equals `pin_in` of the pin carrying s. It reads 1 when s is unplaced.
- R9: `pin_sel` and `overflow` change only on a rising clock edge and reflect the inputs sampled at that edge. While `rst` is high at an edge, all pins become unassigned and `overflow` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uart_en | input | 1 | Enable UART lines |
| spi_en | input | 1 | Enable SPI lines |
| spi_4w | input | 1 | SPI four-wire mode (adds NSS) |
| i2c_en | input | 1 | Enable two-wire serial lines |
| cmp_en | input | 1 | Enable comparator output |
| cmp_async_en | input | 1 | Enable asynchronous comparator output |
| sysclk_en | input | 1 | Enable clock output |
| pca_chans | input | 2 | Number of capture/compare channels routed (0-3) |
| eci_en | input | 1 | Enable counter external clock input |
| t0_en | input | 1 | Enable timer 0 input |
| t1_en | input | 1 | Enable timer 1 input |
| skip_p0 | input | 8 | Skip mask, pins 0-7 |
| skip_p1 | input | 8 | Skip mask, pins 8-15 |
| skip_p2 | input | 8 | Skip mask, pins 16-23 |
| sig_out | input | 17 | Peripheral output value per signal code |
| sig_oe | input | 17 | Peripheral output enable per signal code |
| gpio_latch | input | 24 | GPIO drive value per pin |
| pin_in | input | 24 | Sampled pad value per pin |
| pin_out | output | 24 | Drive value per pin |
| pin_oe | output | 24 | Output enable per pin |
| pin_sel | output | 120 | Signal code per pin, 5 bits each, pin p at bits 5p+4:5p |
| sig_in | output | 17 | Pad value routed back per signal code |
| overflow | output | 1 | A requested signal found no pin |

## Verification
The assertions assume that every configuration input is 2-state and stable around the rising edge, and that `P2_PINS` lies between 1 and 8. They also assume that the UART requests both its lines together, which the request decoder guarantees. The stimulus changes every input only on falling edges and draws all values from 2-state random words or fixed constants. It also sets skip bits on pins 4 and 5 on purpose, so the rule that the UART ignores the masks is exercised without breaking the checks that tie skip bits to unassigned pins.

// File: rtl/pin_xbar_pkg.sv
package pin_xbar_pkg;
  localparam int PORT_W  = 8;
  localparam int N_PORTS = 3;
  localparam int N_PINS  = PORT_W * N_PORTS;
  localparam int N_SIG   = 17;
  localparam int N_CEX   = 3;
  localparam int PCA_W   = $clog2(N_CEX + 1);
  localparam int IDX_W   = 5;
  localparam logic [IDX_W-1:0] UNASG = '1;
  localparam int UART_TX_PIN = 4;
  localparam int UART_RX_PIN = 5;

  typedef enum logic [IDX_W-1:0] {
    S_TX = 5'd0, S_RX, S_SCK, S_MISO, S_MOSI, S_NSS, S_SDA, S_SCL,
    S_CP, S_CPA, S_SYSCLK, S_CEX0, S_CEX1, S_CEX2, S_ECI, S_T0, S_T1
  } sig_e;
endpackage

// File: rtl/xbar_req_decode.sv
module xbar_req_decode
  import pin_xbar_pkg::*;
(
  input  logic             uart_en,
  input  logic             spi_en,
  input  logic             spi_4w,
  input  logic             i2c_en,
  input  logic             cmp_en,
  input  logic             cmp_async_en,
  input  logic             sysclk_en,
  input  logic [PCA_W-1:0] pca_chans,
  input  logic             eci_en,
  input  logic             t0_en,
  input  logic             t1_en,
  output logic [N_SIG-1:0] req
);
  always_comb begin
    req           = '0;
    req[S_TX]     = uart_en;
    req[S_RX]     = uart_en;
    req[S_SCK]    = spi_en;
    req[S_MISO]   = spi_en;
    req[S_MOSI]   = spi_en;
    req[S_NSS]    = spi_en & spi_4w;
    req[S_SDA]    = i2c_en;
    req[S_SCL]    = i2c_en;
    req[S_CP]     = cmp_en;
    req[S_CPA]    = cmp_async_en;
    req[S_SYSCLK] = sysclk_en;
    req[S_ECI]    = eci_en;
    req[S_T0]     = t0_en;
    req[S_T1]     = t1_en;
    for (int k = 0; k < N_CEX; k++)
      req[int'(S_CEX0) + k] = (int'(pca_chans) > k);
  end
endmodule

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import pin_xbar_pkg::*;
#(
  parameter int P2_PINS = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [N_SIG-1:0]               req,
  input  logic [N_PINS-1:0]              skip,
  output logic [N_PINS-1:0][IDX_W-1:0]   sel_c,
  output logic                           ovf_c
);
  localparam logic [N_PINS-1:0] USABLE = {N_PINS{1'b1}} >> (PORT_W - P2_PINS);

  logic uart_on;
  assign uart_on = req[S_TX] | req[S_RX];

  // Greedy walk in rank order; occ marks pins no longer available.
  always_comb begin
    logic [N_PINS-1:0] occ;
    logic found;
    found = 1'b0;
    occ   = skip | ~USABLE;
    sel_c = {N_PINS{UNASG}};
    ovf_c = 1'b0;
    if (uart_on) begin
      occ[UART_TX_PIN]   = 1'b1;
      occ[UART_RX_PIN]   = 1'b1;
      sel_c[UART_TX_PIN] = S_TX;
      sel_c[UART_RX_PIN] = S_RX;
    end
    for (int s = int'(S_SCK); s < N_SIG; s++) begin
      if (req[s]) begin
        found = 1'b0;
        for (int p = 0; p < N_PINS; p++) begin
          if (!found && !occ[p]) begin
            sel_c[p] = IDX_W'(s);
            occ[p]   = 1'b1;
            found    = 1'b1;
          end
        end
        if (!found) ovf_c = 1'b1;
      end
    end
  end

  logic [N_PINS-1:0] unas;
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    localparam bit IS_UART = (p == UART_TX_PIN) || (p == UART_RX_PIN);
    assign unas[p] = (sel_c[p] == UNASG);
    // R2: a skipped pin outside the UART pair stays free of signals
    assert_skip_honored_R2: assert property (@(posedge clk) disable iff (rst)
      (skip[p] && !(IS_UART && uart_on)) |-> unas[p]);
  end

  // R5: overflow only when no usable, unskipped pin remained free
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_c |-> ((unas & ~skip & USABLE) == '0));
endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import pin_xbar_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic [N_PINS-1:0][IDX_W-1:0] sel,
  input  logic [N_SIG-1:0]             sig_out,
  input  logic [N_SIG-1:0]             sig_oe,
  input  logic [N_PINS-1:0]            gpio_latch,
  input  logic [N_PINS-1:0]            pin_in,
  output logic [N_PINS-1:0]            pin_out,
  output logic [N_PINS-1:0]            pin_oe,
  output logic [N_SIG-1:0]             sig_in
);
  logic [N_SIG-1:0][N_PINS-1:0] hit;

  for (genvar s = 0; s < N_SIG; s++) begin : g_sig
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
      assign hit[s][p] = (sel[p] == IDX_W'(s));
    end
    // R1: one signal never lands on two pins
    assert_single_pin_R1: assert property (@(posedge clk) disable iff (rst)
      $countones(hit[s]) <= 1);
  end

  always_comb begin
    pin_out = gpio_latch;
    pin_oe  = '1;
    sig_in  = '1;
    for (int p = 0; p < N_PINS; p++) begin
      for (int s = 0; s < N_SIG; s++) begin
        if (hit[s][p]) begin
          pin_out[p] = sig_out[s];
          pin_oe[p]  = sig_oe[s];
          sig_in[s]  = pin_in[p];
        end
      end
    end
  end

  for (genvar p = 0; p < N_PINS; p++) begin : g_fallback
    // R6: unassigned pins fall back to the GPIO latch
    assert_gpio_fallback_R6: assert property (@(posedge clk) disable iff (rst)
      (sel[p] == UNASG) |-> (pin_oe[p] && pin_out[p] == gpio_latch[p]));
  end
endmodule

// File: rtl/pin_xbar.sv
module pin_xbar
  import pin_xbar_pkg::*;
#(
  parameter int P2_PINS = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      uart_en,
  input  logic                      spi_en,
  input  logic                      spi_4w,
  input  logic                      i2c_en,
  input  logic                      cmp_en,
  input  logic                      cmp_async_en,
  input  logic                      sysclk_en,
  input  logic [PCA_W-1:0]          pca_chans,
  input  logic                      eci_en,
  input  logic                      t0_en,
  input  logic                      t1_en,
  input  logic [PORT_W-1:0]         skip_p0,
  input  logic [PORT_W-1:0]         skip_p1,
  input  logic [PORT_W-1:0]         skip_p2,
  input  logic [N_SIG-1:0]          sig_out,
  input  logic [N_SIG-1:0]          sig_oe,
  input  logic [N_PINS-1:0]         gpio_latch,
  input  logic [N_PINS-1:0]         pin_in,
  output logic [N_PINS-1:0]         pin_out,
  output logic [N_PINS-1:0]         pin_oe,
  output logic [N_PINS*IDX_W-1:0]   pin_sel,
  output logic [N_SIG-1:0]          sig_in,
  output logic                      overflow
);
  logic [N_SIG-1:0]             req_c;
  logic [N_PINS-1:0][IDX_W-1:0] sel_c, sel_q;
  logic                         ovf_c, ovf_q;
  logic                         uart_q, rst_q;

  xbar_req_decode u_dec (
    .uart_en(uart_en), .spi_en(spi_en), .spi_4w(spi_4w), .i2c_en(i2c_en),
    .cmp_en(cmp_en), .cmp_async_en(cmp_async_en), .sysclk_en(sysclk_en),
    .pca_chans(pca_chans), .eci_en(eci_en), .t0_en(t0_en), .t1_en(t1_en),
    .req(req_c)
  );

  xbar_alloc #(.P2_PINS(P2_PINS)) u_alloc (
    .clk(clk), .rst(rst), .req(req_c),
    .skip({skip_p2, skip_p1, skip_p0}),
    .sel_c(sel_c), .ovf_c(ovf_c)
  );

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      sel_q  <= {N_PINS{UNASG}};
      ovf_q  <= 1'b0;
      uart_q <= 1'b0;
    end else begin
      sel_q  <= sel_c;
      ovf_q  <= ovf_c;
      uart_q <= uart_en;
    end
  end

  xbar_route u_route (
    .clk(clk), .rst(rst), .sel(sel_q),
    .sig_out(sig_out), .sig_oe(sig_oe), .gpio_latch(gpio_latch),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .sig_in(sig_in)
  );

  assign pin_sel  = sel_q;
  assign overflow = ovf_q;

  // R3: UART pair pinned to fixed pins whenever it was enabled
  assert_uart_fixed_R3: assert property (@(posedge clk) disable iff (rst)
    uart_q |-> (sel_q[UART_TX_PIN] == S_TX && sel_q[UART_RX_PIN] == S_RX));

  // R9: the edge after a reset leaves no pin assigned
  assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (sel_q == {N_PINS{UNASG}} && !ovf_q));
endmodule

// File: tb/sim_pin_xbar.sv
`timescale 1ns/1ps
module sim_pin_xbar;
  localparam int P2 = 4;
  localparam int NP = 24;
  localparam int NS = 17;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic uart_en = 0, spi_en = 0, spi_4w = 0, i2c_en = 0, cmp_en = 0, cmp_async_en = 0;
  logic sysclk_en = 0, eci_en = 0, t0_en = 0, t1_en = 0;
  logic [1:0] pca_chans = 0;
  logic [7:0] skip_p0 = 0, skip_p1 = 0, skip_p2 = 0;
  logic [NS-1:0] sig_out = 0, sig_oe = 0;
  logic [NP-1:0] gpio_latch = 0, pin_in = 0;
  logic [NP-1:0] pin_out, pin_oe;
  logic [NP*5-1:0] pin_sel;
  logic [NS-1:0] sig_in;
  logic overflow;

  pin_xbar #(.P2_PINS(P2)) u0 (
    .clk(clk), .rst(rst), .uart_en(uart_en), .spi_en(spi_en), .spi_4w(spi_4w),
    .i2c_en(i2c_en), .cmp_en(cmp_en), .cmp_async_en(cmp_async_en),
    .sysclk_en(sysclk_en), .pca_chans(pca_chans), .eci_en(eci_en),
    .t0_en(t0_en), .t1_en(t1_en), .skip_p0(skip_p0), .skip_p1(skip_p1),
    .skip_p2(skip_p2), .sig_out(sig_out), .sig_oe(sig_oe),
    .gpio_latch(gpio_latch), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_sel(pin_sel), .sig_in(sig_in), .overflow(overflow)
  );

  int checks = 0, errors = 0;
  int exp_sel[NP];
  int prev_sel[NP];
  int exp_ovf;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, expv);
    end
  endtask

  // Expected allocation derived from the requirement text.
  task automatic model();
    bit rq[NS];
    bit occ[NP];
    bit got;
    rq[0] = uart_en; rq[1] = uart_en;
    rq[2] = spi_en; rq[3] = spi_en; rq[4] = spi_en;
    rq[5] = spi_en && spi_4w;                     // R4
    rq[6] = i2c_en; rq[7] = i2c_en;
    rq[8] = cmp_en; rq[9] = cmp_async_en; rq[10] = sysclk_en;
    for (int k = 0; k < 3; k++) rq[11+k] = (pca_chans > k);
    rq[14] = eci_en; rq[15] = t0_en; rq[16] = t1_en;
    exp_ovf = 0;
    for (int p = 0; p < NP; p++) begin
      exp_sel[p] = 31;
      occ[p] = ({skip_p2, skip_p1, skip_p0} >> p) & 1'b1;
      if (p >= 16 + P2) occ[p] = 1;                // R5
    end
    if (uart_en) begin                              // R3
      exp_sel[4] = 0; exp_sel[5] = 1; occ[4] = 1; occ[5] = 1;
    end
    for (int s = 2; s < NS; s++) begin              // R1
      if (rq[s]) begin
        got = 0;
        for (int p = 0; p < NP; p++)
          if (!got && !occ[p]) begin exp_sel[p] = s; occ[p] = 1; got = 1; end
        if (!got) exp_ovf = 1;
      end
    end
  endtask

  task automatic check_all();
    int pin_of;
    for (int p = 0; p < NP; p++) begin
      chk(pin_sel[5*p +: 5] == exp_sel[p], "R1/R2/R3/R5 pin_sel", int'(pin_sel[5*p +: 5]), exp_sel[p]);
      if (exp_sel[p] == 31) begin
        chk(pin_out[p] == gpio_latch[p] && pin_oe[p], "R6 gpio fallback",
            int'({pin_oe[p], pin_out[p]}), int'({1'b1, gpio_latch[p]}));
      end else begin
        chk(pin_out[p] == sig_out[exp_sel[p]] && pin_oe[p] == sig_oe[exp_sel[p]], "R7 drive",
            int'({pin_oe[p], pin_out[p]}), int'({sig_oe[exp_sel[p]], sig_out[exp_sel[p]]}));
      end
    end
    for (int s = 0; s < NS; s++) begin
      pin_of = -1;
      for (int p = 0; p < NP; p++) if (exp_sel[p] == s) pin_of = p;
      chk(sig_in[s] == ((pin_of < 0) ? 1'b1 : pin_in[pin_of]), "R8 sig_in",
          int'(sig_in[s]), (pin_of < 0) ? 1 : int'(pin_in[pin_of]));
    end
    chk(overflow == exp_ovf[0], "R5 overflow", int'(overflow), exp_ovf);
  endtask

  task automatic randomize_data();
    sig_out = NS'($urandom); sig_oe = NS'($urandom);
    gpio_latch = NP'($urandom); pin_in = NP'($urandom);
  endtask

  // Inputs change at the falling edge; result is due after the next rising edge.
  task automatic apply_and_check();
    for (int p = 0; p < NP; p++) prev_sel[p] = exp_sel[p];
    #1;
    for (int p = 0; p < NP; p++)        // R9: nothing moves before the edge
      chk(pin_sel[5*p +: 5] == prev_sel[p], "R9 hold until edge", int'(pin_sel[5*p +: 5]), prev_sel[p]);
    model();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic set_all(input bit v);
    uart_en = v; spi_en = v; spi_4w = v; i2c_en = v; cmp_en = v; cmp_async_en = v;
    sysclk_en = v; eci_en = v; t0_en = v; t1_en = v; pca_chans = v ? 2'd3 : 2'd0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) exp_sel[p] = 31;
    exp_ovf = 0;
    // R9 reset: enables high, yet every pin must read unassigned
    @(negedge clk);
    set_all(1); randomize_data();
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++)
      chk(pin_sel[5*p +: 5] == 5'd31, "R9 reset clears", int'(pin_sel[5*p +: 5]), 31);
    chk(overflow == 1'b0, "R9 reset overflow", int'(overflow), 0);
    rst = 1'b0;
    model();
    @(posedge clk); @(negedge clk);
    check_all();                                   // R1 all enabled, nothing skipped

    @(negedge clk); skip_p0 = 8'h30; randomize_data();
    apply_and_check();                             // R3 UART ignores skip on 4,5

    @(negedge clk); set_all(0); spi_en = 1; spi_4w = 0; skip_p0 = 8'h0C; randomize_data();
    apply_and_check();                             // R4 three-wire: no NSS
    @(negedge clk); spi_4w = 1; randomize_data();
    apply_and_check();                             // R4 four-wire adds NSS

    @(negedge clk); set_all(1); skip_p0 = 8'hFF; skip_p1 = 8'hFE; skip_p2 = 8'h00; randomize_data();
    apply_and_check();                             // R5 overflow with few free pins

    @(negedge clk); skip_p0 = 8'h00; skip_p1 = 8'h00; uart_en = 0; randomize_data();
    apply_and_check();                             // R1 no UART, pins 4,5 reused

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      @(negedge clk);
      r = $urandom;
      {uart_en, spi_en, spi_4w, i2c_en, cmp_en, cmp_async_en, sysclk_en,
       eci_en, t0_en, t1_en, pca_chans} = r[11:0] | ((i % 4 == 0) ? 12'hFFF : 12'h000);
      case (i % 3)
        0: {skip_p2, skip_p1, skip_p0} = 24'h0;
        1: {skip_p2, skip_p1, skip_p0} = 24'($urandom & $urandom & $urandom);
        default: {skip_p2, skip_p1, skip_p0} = 24'($urandom | $urandom);
      endcase
      randomize_data();
      apply_and_check();                           // R1 R2 R3 R4 R5 R6 R7 R8 R9
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule